// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a 16-bit parallel NOR-style flash device. It watches bus write cycles and recognises command sequences that begin with a two-write unlock prefix. The commands it knows are identification (autoselect) entry, single-word program, secured-area entry and secured-area exit. A bare reset opcode takes the device out of identification mode. From these sequences it sets a read-mode selector. The selector decides what a read returns: array data, identification words, the secured serial-number area, or program status.

A fourth write that follows a program set-up latches the target address and data word. It starts the array's internal program operation with a one-cycle pulse. The block then ignores every write until the array reports completion. A status word takes the place of read data while programming runs. The secured-area mode is sticky: it ends only on a dedicated four-write exit sequence. Asserting the hardware reset aborts any program in flight.

Writes and reads arrive on valid/ready channels. Both ready outputs are held high, so the block never applies back-pressure. Every write presented with `wr_valid` is taken on that clock edge. A write taken while busy is discarded, not stalled. A read taken on an edge produces exactly one response on the next cycle. The response channel has no ready, so the consumer must accept the response when it appears.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `rd_mode` is 0 (array), `pgm_start` and `rsp_valid` are low, and a read returns `array_rdata` one cycle after `rd_valid`, with `rsp_valid` high for exactly that cycle.
- R2: In array mode, the writes AAh to 555h, 55h to 2AAh and 90h to 555h set `rd_mode` to 1 (identification) after the edge that takes the third write. Only address bits [10:0] and data bits [7:0] are compared.
- R3: In identification mode, the read offset is `rd_addr[7:0]`. Offset 00h returns `MFR_CODE`, and offsets 01h, 0Eh and 0Fh return `DEV_CODE1`, `DEV_CODE2` and `DEV_CODE3`. Offset 02h returns 0001h if `sect_prot[rd_addr[ADDR_W-1 -: SECT_W]]` is set and 0000h if it is clear. Any other offset returns 0000h. The mode holds through any number of reads.
- R4: A write whose data[7:0] is F0h is a reset command when the block is not busy and is not waiting for program data. From identification mode it returns `rd_mode` to 0. Every other write made in identification mode is ignored.
- R5: The writes AAh to 555h, 55h to 2AAh, A0h to 555h, then any address and data, set `rd_mode` to 3 (status). `pgm_start` is high for exactly the one cycle after the fourth write. From that cycle on, `pgm_addr` and `pgm_data` hold the fourth write's address and data, and stay stable while programming runs. F0h in that fourth write is data, not a reset.
- R6: A status read returns 0000h with two bits set from state. Bit 7 is the complement of `pgm_data[7]`. Bit 6 is 0 on the first status read after a program starts and inverts on each later status read.
- R7: While `rd_mode` is 3, every write is ignored. No command sequence is tracked and `pgm_start` stays low.
- R8: When `pgm_done` is high in status mode, `rd_mode` returns to 0 on that edge, and `pgm_addr` and `pgm_data` clear to 0. Reads then return array data.
- R9: Driving `rst_n` low during a program at once forces `rd_mode` to 0 and `pgm_start` low. The aborted word is not written.
- R10: In array mode, AAh to 555h, 55h to 2AAh and 88h to 555h set `rd_mode` to 2 (secured). There, a read with `rd_addr[ADDR_W-1:3]` zero returns `ESN_BASE + rd_addr[2:0]`, and any other address returns FFFFh.
- R11: In secured mode, F0h, identification sequences and program sequences leave `rd_mode` at 2. Only AAh to 555h, 55h to 2AAh, 90h to 555h, then 00h (data[7:0]) at any address, return it to 0. A fourth write other than 00h cancels the exit.
- R12: A write that does not match the next expected cycle of a sequence discards the partial sequence. That write does not begin a new sequence, so the next sequence must start again from its first unlock write.
- R13: Program operations may target any addresses in any order, including addresses in different sectors. Each programmed word reads back after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| wr_valid | input | 1 | Bus write cycle present |
| wr_ready | output | 1 | Always high; writes are never stalled |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Always high |
| rd_addr | input | ADDR_W | Word address of the read |
| array_rdata | input | 16 | Array word at `rd_addr`, valid in the request cycle |
| sect_prot | input | 2**SECT_W | Per-sector protection flags |
| rsp_valid | output | 1 | Read response present, one cycle after the request |
| rsp_data | output | 16 | Read response word |
| rd_mode | output | 2 | 0 array, 1 identification, 2 secured, 3 status |
| pgm_start | output | 1 | One-cycle program launch pulse |
| pgm_addr | output | ADDR_W | Latched program address |
| pgm_data | output | 16 | Latched program data |
| pgm_done | input | 1 | Array reports program completion |

## Verification
The main function is driven with complete sequences for each command. It is also driven with sequences that break at the second or third cycle, and with a stray write after a break, which separates "discard and restart" from "reuse the breaking write". Command writes and reset opcodes are issued while a program is busy, and a reset opcode is used as program data. These show whether the busy gate and the argument-position exemption work. In secured mode, foreign sequences and an exit with a wrong final word check that the mode stays sticky. Identification reads walk every defined offset plus an undefined one, across protected and unprotected sectors.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_SECURE = 2'd2,
    RM_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM_ARG,
    SQ_EXIT_ARG
  } seq_e;

  typedef struct packed {
    logic go_ident;
    logic go_secure;
    logic leave_secure;
    logic go_program;
    logic soft_reset;
  } seq_evt_t;

  localparam logic [10:0] KEY1_ADDR  = 11'h555;
  localparam logic [10:0] KEY2_ADDR  = 11'h2AA;
  localparam logic [7:0]  KEY1_DATA  = 8'hAA;
  localparam logic [7:0]  KEY2_DATA  = 8'h55;
  localparam logic [7:0]  OP_IDENT   = 8'h90;
  localparam logic [7:0]  OP_PROGRAM = 8'hA0;
  localparam logic [7:0]  OP_SECURE  = 8'h88;
  localparam logic [7:0]  OP_LEAVE   = 8'h00;
  localparam logic [7:0]  OP_RESET   = 8'hF0;
  localparam int          ESN_WORDS  = 8;

endpackage

// File: rtl/fcs_seq_decoder.sv
module fcs_seq_decoder
  import fcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic [10:0] key_addr,
  input  logic [7:0]  op,
  input  logic        busy,
  input  logic        in_ident,
  input  logic        in_secure,
  output seq_evt_t    evt
);

  seq_e st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    evt   = '0;
    if (wr_fire && !busy) begin
      if (op == OP_RESET && st != SQ_PGM_ARG) begin
        evt.soft_reset = 1'b1;
        st_nx          = SQ_IDLE;
      end else if (in_ident) begin
        st_nx = SQ_IDLE;
      end else begin
        unique case (st)
          SQ_IDLE: begin
            if (key_addr == KEY1_ADDR && op == KEY1_DATA) st_nx = SQ_KEY1;
          end
          SQ_KEY1: begin
            st_nx = (key_addr == KEY2_ADDR && op == KEY2_DATA) ? SQ_KEY2 : SQ_IDLE;
          end
          SQ_KEY2: begin
            st_nx = SQ_IDLE;
            if (key_addr == KEY1_ADDR) begin
              if (in_secure) begin
                if (op == OP_IDENT) st_nx = SQ_EXIT_ARG;
              end else begin
                if (op == OP_IDENT)   evt.go_ident  = 1'b1;
                if (op == OP_SECURE)  evt.go_secure = 1'b1;
                if (op == OP_PROGRAM) st_nx         = SQ_PGM_ARG;
              end
            end
          end
          SQ_PGM_ARG: begin
            evt.go_program = 1'b1;
            st_nx          = SQ_IDLE;
          end
          SQ_EXIT_ARG: begin
            if (op == OP_LEAVE) evt.leave_secure = 1'b1;
            st_nx = SQ_IDLE;
          end
          default: st_nx = SQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/fcs_mode_ctl.sv
module fcs_mode_ctl
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_evt_t          evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_fire,
  input  logic              pgm_done,
  output rd_mode_e          mode,
  output logic              pgm_start,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [15:0]       pgm_data,
  output logic              tog
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= RM_ARRAY;
      pgm_start <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
      tog       <= 1'b0;
    end else begin
      pgm_start <= 1'b0;
      unique case (mode)
        RM_STATUS: begin
          if (pgm_done) begin
            mode     <= RM_ARRAY;
            pgm_addr <= '0;
            pgm_data <= '0;
          end else if (rd_fire) begin
            tog <= ~tog;
          end
        end
        RM_ARRAY: begin
          if (evt.go_ident) begin
            mode <= RM_IDENT;
          end else if (evt.go_secure) begin
            mode <= RM_SECURE;
          end else if (evt.go_program) begin
            mode      <= RM_STATUS;
            pgm_start <= 1'b1;
            pgm_addr  <= wr_addr;
            pgm_data  <= wr_data;
            tog       <= 1'b0;
          end
        end
        RM_IDENT: begin
          if (evt.soft_reset) mode <= RM_ARRAY;
        end
        RM_SECURE: begin
          if (evt.leave_secure) mode <= RM_ARRAY;
        end
        default: mode <= RM_ARRAY;
      endcase
    end
  end

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
  import fcs_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          SECT_W    = 3,
  parameter logic [15:0] MFR_CODE  = 16'h00A5,
  parameter logic [15:0] DEV_CODE1 = 16'h3C10,
  parameter logic [15:0] DEV_CODE2 = 16'h3C21,
  parameter logic [15:0] DEV_CODE3 = 16'h3C32,
  parameter logic [15:0] ESN_BASE  = 16'hC0DE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_fire,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  rd_mode_e              mode,
  input  logic                  tog,
  input  logic                  pgm_d7,
  input  logic [15:0]           array_rdata,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  output logic                  rsp_valid,
  output logic [15:0]           rsp_data
);

  localparam int IDX_W = $clog2(ESN_WORDS);

  logic [15:0]       esn_word [ESN_WORDS];
  logic [15:0]       ident_word, secure_word, status_word, rd_word;
  logic [SECT_W-1:0] sect_idx;

  for (genvar g = 0; g < ESN_WORDS; g++) begin : g_esn
    assign esn_word[g] = ESN_BASE + 16'(g);
  end

  assign sect_idx = rd_addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    unique case (rd_addr[7:0])
      8'h00:   ident_word = MFR_CODE;
      8'h01:   ident_word = DEV_CODE1;
      8'h0E:   ident_word = DEV_CODE2;
      8'h0F:   ident_word = DEV_CODE3;
      8'h02:   ident_word = {15'b0, sect_prot[sect_idx]};
      default: ident_word = 16'h0000;
    endcase
  end

  assign secure_word = (rd_addr[ADDR_W-1:IDX_W] == '0) ? esn_word[rd_addr[IDX_W-1:0]]
                                                       : 16'hFFFF;
  assign status_word = {8'h00, ~pgm_d7, tog, 6'b0};

  always_comb begin
    unique case (mode)
      RM_IDENT:  rd_word = ident_word;
      RM_SECURE: rd_word = secure_word;
      RM_STATUS: rd_word = status_word;
      default:   rd_word = array_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= rd_word;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          SECT_W    = 3,
  parameter logic [15:0] MFR_CODE  = 16'h00A5,
  parameter logic [15:0] DEV_CODE1 = 16'h3C10,
  parameter logic [15:0] DEV_CODE2 = 16'h3C21,
  parameter logic [15:0] DEV_CODE3 = 16'h3C32,
  parameter logic [15:0] ESN_BASE  = 16'hC0DE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [15:0]            wr_data,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [15:0]            array_rdata,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  output logic                   rsp_valid,
  output logic [15:0]            rsp_data,
  output logic [1:0]             rd_mode,
  output logic                   pgm_start,
  output logic [ADDR_W-1:0]      pgm_addr,
  output logic [15:0]            pgm_data,
  input  logic                   pgm_done
);

  seq_evt_t evt;
  rd_mode_e mode;
  logic     tog, wr_fire, rd_fire;

  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_mode  = mode;

  fcs_seq_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .key_addr  (wr_addr[10:0]),
    .op        (wr_data[7:0]),
    .busy      (mode == RM_STATUS),
    .in_ident  (mode == RM_IDENT),
    .in_secure (mode == RM_SECURE),
    .evt       (evt)
  );

  fcs_mode_ctl #(.ADDR_W(ADDR_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_fire   (rd_fire),
    .pgm_done  (pgm_done),
    .mode      (mode),
    .pgm_start (pgm_start),
    .pgm_addr  (pgm_addr),
    .pgm_data  (pgm_data),
    .tog       (tog)
  );

  fcs_read_mux #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .MFR_CODE(MFR_CODE), .DEV_CODE1(DEV_CODE1),
    .DEV_CODE2(DEV_CODE2), .DEV_CODE3(DEV_CODE3), .ESN_BASE(ESN_BASE)
  ) u_rmux (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (rd_fire),
    .rd_addr     (rd_addr),
    .mode        (mode),
    .tog         (tog),
    .pgm_d7      (pgm_data[7]),
    .array_rdata (array_rdata),
    .sect_prot   (sect_prot),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              rd_valid,
  input logic              rsp_valid,
  input logic [1:0]        rd_mode,
  input logic              pgm_start,
  input logic              pgm_done,
  input logic [ADDR_W-1:0] pgm_addr,
  input logic [15:0]       pgm_data
);

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);

  assert_pgm_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |=> !pgm_start);

  assert_pgm_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> rd_mode == 2'd3);

  assert_pgm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd3) |=> (rd_mode != 2'd3 || ($stable(pgm_addr) && $stable(pgm_data))));

  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd3) |=> !pgm_start);

  assert_done_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd3 && pgm_done) |=> (rd_mode == 2'd0 && pgm_addr == '0 && pgm_data == '0));

  assert_secure_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2 && !wr_valid) |=> rd_mode == 2'd2);

  assert_secure_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2) |=> (rd_mode == 2'd2 || rd_mode == 2'd0));

endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W)) u_fcs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .rd_valid  (rd_valid),
  .rsp_valid (rsp_valid),
  .rd_mode   (rd_mode),
  .pgm_start (pgm_start),
  .pgm_done  (pgm_done),
  .pgm_addr  (pgm_addr),
  .pgm_data  (pgm_data)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;

  localparam int          ADDR_W = 16;
  localparam int          SECT_W = 3;
  localparam logic [15:0] MFR    = 16'h00A5;
  localparam logic [15:0] DEV1   = 16'h3C10;
  localparam logic [15:0] DEV2   = 16'h3C21;
  localparam logic [15:0] DEV3   = 16'h3C32;
  localparam logic [15:0] ESNB   = 16'hC0DE;
  localparam int          PGM_LAT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, array_rdata = 16'hFFFF;
  logic [7:0]  sect_prot = 8'b0001_0100;
  logic wr_ready, rd_ready, rsp_valid, pgm_start, pgm_done;
  logic [15:0] rsp_data, pgm_data;
  logic [1:0]  rd_mode;
  logic [ADDR_W-1:0] pgm_addr;

  int n_cmp = 0, n_bad = 0;
  bit fin = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .MFR_CODE(MFR), .DEV_CODE1(DEV1),
    .DEV_CODE2(DEV2), .DEV_CODE3(DEV3), .ESN_BASE(ESNB)
  ) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .sect_prot(sect_prot),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rd_mode(rd_mode),
    .pgm_start(pgm_start), .pgm_addr(pgm_addr), .pgm_data(pgm_data), .pgm_done(pgm_done)
  );

  // behavioural array
  logic [15:0] mem [int];
  int pend = 0;
  logic [ADDR_W-1:0] pa;
  logic [15:0] pd;
  assign pgm_done = (pend == 1);

  function automatic logic [15:0] lookup(input logic [ADDR_W-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) pend <= 0;
    else if (pgm_start) begin
      pend <= PGM_LAT; pa = pgm_addr; pd = pgm_data;
    end else if (pend != 0) begin
      if (pend == 1) mem[int'(pa)] = pd;
      pend <= pend - 1;
    end
  end

  // reference model
  int m_mode = 0;
  int q_op[$];
  bit m_start = 0, m_tog = 0, nxt_start = 0, e_rv = 0;
  logic [15:0] e_rd = '0, m_pd = '0;
  logic [ADDR_W-1:0] m_pa = '0;

  function automatic logic [15:0] model_read(input logic [ADDR_W-1:0] a);
    int sect;
    sect = int'(a) >> (ADDR_W - SECT_W);
    case (m_mode)
      1: begin
        if (a[7:0] == 8'h00) return MFR;
        if (a[7:0] == 8'h01) return DEV1;
        if (a[7:0] == 8'h0E) return DEV2;
        if (a[7:0] == 8'h0F) return DEV3;
        if (a[7:0] == 8'h02) return sect_prot[sect] ? 16'h0001 : 16'h0000;
        return 16'h0000;
      end
      2: return (int'(a) < 8) ? ESNB + 16'(int'(a)) : 16'hFFFF;
      3: return {8'h00, ~m_pd[7], m_tog, 6'b0};
      default: return array_rdata;
    endcase
  endfunction

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    logic [7:0] op; logic [10:0] k; int n; bit ok;
    op = d[7:0]; k = a[10:0]; n = q_op.size();
    if (op == 8'hF0 && !(m_mode == 0 && n == 3)) begin
      if (m_mode == 1) m_mode = 0;
      q_op.delete(); return;
    end
    if (m_mode == 1) return;
    case (n)
      0: ok = (k == 11'h555 && op == 8'hAA);
      1: ok = (k == 11'h2AA && op == 8'h55);
      2: ok = (k == 11'h555) && ((m_mode == 2) ? (op == 8'h90)
                                : (op == 8'h90 || op == 8'hA0 || op == 8'h88));
      3: ok = 1;
      default: ok = 0;
    endcase
    if (!ok) begin q_op.delete(); return; end
    if (n == 2 && m_mode == 0 && op != 8'hA0) begin
      m_mode = (op == 8'h90) ? 1 : 2; q_op.delete(); return;
    end
    if (n == 3) begin
      if (m_mode == 0) begin
        m_mode = 3; m_pa = a; m_pd = d; m_tog = 0; nxt_start = 1;
      end else if (op == 8'h00) m_mode = 0;
      q_op.delete(); return;
    end
    q_op.push_back(int'(op));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; q_op.delete(); m_start = 0; m_tog = 0; e_rv = 0;
      m_pa = '0; m_pd = '0;
    end else begin
      nxt_start = 0;
      e_rv = rd_valid;
      if (rd_valid) e_rd = model_read(rd_addr);
      if (m_mode == 3) begin
        if (pgm_done) begin m_mode = 0; m_pa = '0; m_pd = '0; end
        else if (rd_valid) m_tog = ~m_tog;
      end else if (wr_valid) model_write(wr_addr, wr_data);
      m_start = nxt_start;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk({phase, " rd_mode"}, 32'(rd_mode), 32'(m_mode));
      chk({phase, " pgm_start"}, 32'(pgm_start), 32'(m_start));
      chk({phase, " pgm_addr"}, 32'(pgm_addr), 32'(m_pa));
      chk({phase, " pgm_data"}, 32'(pgm_data), 32'(m_pd));
      chk({phase, " rsp_valid"}, 32'(rsp_valid), 32'(e_rv));
      if (e_rv) chk({phase, " rsp_data"}, 32'(rsp_data), 32'(e_rd));
    end
  end

  // stimulus helpers, called at a falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    rd_valid = 1'b1; rd_addr = a; array_rdata = lookup(a);
    @(negedge clk); rd_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [15:0] exp);
    rd(a);
    chk(tag, 32'(rsp_data), 32'(exp));
  endtask

  task automatic unlock(input logic [7:0] op);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, {8'h00, op});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && rd_mode == 2'd3; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary(); $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    phase = "R1";
    chk("R1 mode after reset", 32'(rd_mode), 32'd0);
    chk("R1 pgm_start after reset", 32'(pgm_start), 32'd0);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    rd_chk("R1 blank array read", 16'h0040, 16'hFFFF);

    // R5 R6 R8 program and status
    phase = "R5";
    unlock(8'hA0); wr(16'h0123, 16'h5A3C);
    chk("R5 pgm_start pulse", 32'(pgm_start), 32'd1);
    chk("R5 pgm_addr", 32'(pgm_addr), 32'h0123);
    chk("R5 status mode", 32'(rd_mode), 32'd3);
    phase = "R6";
    rd_chk("R6 first status", 16'h7777, 16'h0080);
    rd_chk("R6 second status", 16'h0001, 16'h00C0);
    rd_chk("R6 third status", 16'h0123, 16'h0080);
    phase = "R8";
    wait_idle();
    chk("R8 back to array", 32'(rd_mode), 32'd0);
    chk("R8 address dropped", 32'(pgm_addr), 32'd0);
    rd_chk("R8 programmed word", 16'h0123, 16'h5A3C);

    // R7 writes ignored while busy
    phase = "R7";
    unlock(8'hA0); wr(16'h8000, 16'h1280);
    unlock(8'h90); wr(16'h0000, 16'h00F0); unlock(8'hA0); wr(16'h9000, 16'h1111);
    chk("R7 still busy", 32'(rd_mode), 32'd3);
    rd_chk("R7 status bit7 clear", 16'h0000, 16'h0000);
    wait_idle();
    chk("R7 returns to array not ident", 32'(rd_mode), 32'd0);
    rd_chk("R7 no stray program", 16'h9000, 16'hFFFF);

    // R13 other sector, F0 as program data
    phase = "R13";
    unlock(8'hA0); wr(16'h7FFF, 16'h12F0);
    chk("R13 F0 taken as data", 32'(rd_mode), 32'd3);
    wait_idle();
    rd_chk("R13 sector 3 word", 16'h7FFF, 16'h12F0);
    rd_chk("R13 sector 4 word", 16'h8000, 16'h1280);

    // R2 R3 identification
    phase = "R2";
    unlock(8'h90);
    chk("R2 ident mode", 32'(rd_mode), 32'd1);
    phase = "R3";
    rd_chk("R3 manufacturer", 16'h0000, MFR);
    rd_chk("R3 device 1", 16'h5501, DEV1);
    rd_chk("R3 device 2", 16'h000E, DEV2);
    rd_chk("R3 device 3", 16'h000F, DEV3);
    rd_chk("R3 protected sector", 16'h4002, 16'h0001);
    rd_chk("R3 open sector", 16'h6002, 16'h0000);
    rd_chk("R3 undefined offset", 16'h0005, 16'h0000);
    chk("R3 mode held", 32'(rd_mode), 32'd1);

    // R4 reset command
    phase = "R4";
    wr(16'h0555, 16'h00AA); wr(16'h0555, 16'h00A0);
    chk("R4 other writes ignored", 32'(rd_mode), 32'd1);
    wr(16'h1234, 16'h00F0);
    chk("R4 reset to array", 32'(rd_mode), 32'd0);
    rd_chk("R4 array visible", 16'h0123, 16'h5A3C);

    // R12 broken sequences
    phase = "R12";
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0123, 16'h0090);
    chk("R12 wrong third address", 32'(rd_mode), 32'd0);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0011); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0090);
    chk("R12 no restart from break", 32'(rd_mode), 32'd0);
    unlock(8'h90);
    chk("R12 fresh sequence works", 32'(rd_mode), 32'd1);
    wr(16'h0000, 16'h00F0);

    // R10 secured area
    phase = "R10";
    unlock(8'h88);
    chk("R10 secure mode", 32'(rd_mode), 32'd2);
    rd_chk("R10 serial word 3", 16'h0003, ESNB + 16'd3);
    rd_chk("R10 serial word 7", 16'h0007, ESNB + 16'd7);
    rd_chk("R10 outside serial", 16'h0010, 16'hFFFF);

    // R11 sticky secured mode
    phase = "R11";
    wr(16'h0000, 16'h00F0);
    chk("R11 F0 keeps secure", 32'(rd_mode), 32'd2);
    unlock(8'h90); wr(16'h0000, 16'h0011);
    chk("R11 bad exit word", 32'(rd_mode), 32'd2);
    unlock(8'hA0); wr(16'h0300, 16'h4444);
    chk("R11 program rejected", 32'(rd_mode), 32'd2);
    unlock(8'h90); wr(16'h4444, 16'h0000);
    chk("R11 exit to array", 32'(rd_mode), 32'd0);
    rd_chk("R11 no secure program", 16'h0300, 16'hFFFF);

    // R9 hardware reset abort
    phase = "R9";
    unlock(8'hA0); wr(16'h0200, 16'hBEEF);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk("R9 mode forced", 32'(rd_mode), 32'd0);
    chk("R9 start low", 32'(pgm_start), 32'd0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R9 stays array", 32'(rd_mode), 32'd0);
    rd_chk("R9 word not written", 16'h0200, 16'hFFFF);

    repeat (2) @(negedge clk);
    fin = 1;
    summary();
    $finish;
  end

endmodule